// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block is the receive half of a 16550-style serial port, after the bit-level deserialiser. Each received character is presented for one clock with a valid strobe. Characters come from the line or, in loopback mode, from the transmitter. The block keeps them in a 16-entry first-in first-out queue. When queue mode is off, it keeps them in a single holding register instead. Software reads them one at a time through a data-read strobe.

In queue mode, data-ready and the receive interrupt are raised in one of two cases. The first is when the number of stored characters reaches a selectable threshold. The second is when a quiet period of four character times has passed with data still waiting. If a character arrives and cannot be stored, an overrun flag is set, and it stays set until the line status is read.

The block also ranks every interrupt source of the port by priority. It produces the interrupt identification byte and the interrupt request. The transmit-empty and modem-status sources come in from outside the block.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: After reset, queue mode is off, loopback is off, data_ready and overrun are 0, iid reads 0x01 and irq is 0.
- R2: In queue mode, reads return characters oldest first; rd_data always shows the oldest stored character, and each rd_strobe removes it.
- R3: The threshold is chosen by fcr_trig_sel: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. In queue mode, data_ready and the receive-data interrupt rise on the clock edge that stores the character making the count reach the threshold, and not before.
- R4: In queue mode, a character arriving while all 16 entries are full is discarded, the stored contents are unchanged, and overrun is set.
- R5: With queue mode off, a character overwrites the holding register and sets data_ready. If data_ready was already 1 when it arrived, overrun is set as well. A read clears data_ready.
- R6: In queue mode, every arriving character and every read that leaves data stored restarts a timer of 4 x frame_bits bit_tick pulses. When the timer expires, data_ready is set and a timeout interrupt (code 0xC) is raised.
- R7: A read clears a pending timeout interrupt. A read that empties the queue clears data_ready and the receive-data interrupt; a read that leaves data keeps data_ready.
- R8: iid[3:0] ranks the pending enabled sources, highest first: overrun with int_en[2] gives 0x6; timeout with int_en[0] gives 0xC; receive data with int_en[0] gives 0x4; tx_empty_pend with int_en[1] gives 0x2; modem_pend with int_en[3] gives 0x0.
- R9: With no source pending, iid[3:0] is 0x1 and irq is 0; otherwise irq is 1. iid[7:6] is 11 in queue mode and 00 otherwise, and iid[5:4] is 00.
- R10: A write that changes fcr_enable, or a write with fcr_enable 0, empties the store and clears data_ready, the receive-data interrupt and the timeout interrupt.
- R11: While loopback is on, rx_valid is ignored and lb_valid/lb_data feed the store. A write to mcr_loop that changes its value empties the store as in R10.
- R12: lsr_rd clears overrun. A write with fcr_rx_clear set empties the store as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Character received from the line |
| rx_data | input | 8 | Line character |
| lb_valid | input | 1 | Character sent by the transmitter (loopback source) |
| lb_data | input | 8 | Loopback character |
| rd_strobe | input | 1 | Data register read |
| lsr_rd | input | 1 | Line status read, clears overrun |
| fcr_wr | input | 1 | Write to the queue control fields |
| fcr_enable | input | 1 | Queue mode enable value |
| fcr_rx_clear | input | 1 | Empty the receive store |
| fcr_trig_sel | input | 2 | Threshold select |
| mcr_wr | input | 1 | Write of the loopback control bit |
| mcr_loop | input | 1 | Loopback enable value |
| int_en | input | 4 | Enables: 0 receive/timeout, 1 transmit empty, 2 line status, 3 modem |
| tx_empty_pend | input | 1 | Transmit-empty source pending |
| modem_pend | input | 1 | Modem-status source pending |
| bit_tick | input | 1 | One pulse per bit period |
| frame_bits | input | 4 | Bits per character frame |
| rd_data | output | 8 | Oldest stored character |
| data_ready | output | 1 | Data-ready status |
| overrun | output | 1 | Overrun status |
| iid | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |

## Verification
Every result is held in a register that is written on the clock edge that samples the stimulus, so each output is due one edge after that edge. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and model and outputs are compared 1 ns later, on every cycle. The timeout is due on the edge that samples the (4 x frame_bits)-th tick after the last restart. The directed checks sample on the falling edge one tick before and exactly on that point, so an off-by-one timer is caught.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam logic [3:0] CODE_NONE  = 4'h1;
  localparam logic [3:0] CODE_LINE  = 4'h6;
  localparam logic [3:0] CODE_TMO   = 4'hC;
  localparam logic [3:0] CODE_DATA  = 4'h4;
  localparam logic [3:0] CODE_TXE   = 4'h2;
  localparam logic [3:0] CODE_MODEM = 4'h0;

  // threshold in characters for a select value
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // quiet period in bit ticks: four character times
  function automatic int unsigned tmo_ticks(input int unsigned frame);
    return 4 * frame;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_mode,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] level,
  output logic [CW-1:0] level_next,
  output logic          push_drop
);

  logic [DW-1:0] mem_q   [DEPTH];
  logic [DW-1:0] mem_nxt [DEPTH];
  logic [CW-1:0] cnt_q, cnt_mid, cnt_nxt;
  logic          do_pop, push_take;
  logic [AW-1:0] wr_idx;

  assign do_pop    = pop && (cnt_q != '0);
  assign cnt_mid   = cnt_q - CW'(do_pop);
  assign push_drop = push && !flush && !single_mode && (cnt_mid == CW'(DEPTH));
  assign push_take = push && !flush && !push_drop;
  assign wr_idx    = single_mode ? '0 : cnt_mid[AW-1:0];

  always_comb begin
    if (flush)            cnt_nxt = '0;
    else if (single_mode) cnt_nxt = push_take ? CW'(1) : cnt_mid;
    else                  cnt_nxt = cnt_mid + CW'(push_take);
  end

  always_comb begin
    mem_nxt = mem_q;
    if (do_pop && !single_mode && !flush) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_nxt[i] = mem_q[i+1];
    end
    if (push_take) mem_nxt[wr_idx] = push_data;
  end

  always_ff @(posedge clk) mem_q <= mem_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign head       = mem_q[0];
  assign level      = cnt_q;
  assign level_next = cnt_nxt;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && !single_mode && cnt_q < CW'(DEPTH)) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && !single_mode && cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH) && $stable(head)));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int unsigned TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          stop,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expire
);

  logic          armed_q;
  logic [TW-1:0] cnt_q;

  assign expire = armed_q && tick && !restart && !stop && (cnt_q == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (stop) begin
      armed_q <= 1'b0;
    end else if (restart) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (expire) begin
      armed_q <= 1'b0;
    end else if (armed_q && tick) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  // R6
  tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !stop) |=> !expire);

endmodule

// File: rtl/rxq_irq_pick.sv
module rxq_irq_pick
  import rxq_pkg::*;
(
  input  logic [3:0] int_en,
  input  logic       line_pend,
  input  logic       tmo_pend,
  input  logic       data_pend,
  input  logic       txe_pend,
  input  logic       modem_pend,
  input  logic       fifo_mode,
  output logic [7:0] iid,
  output logic       irq
);

  logic [3:0] code;

  always_comb begin
    if (int_en[2] && line_pend)      code = CODE_LINE;
    else if (int_en[0] && tmo_pend)  code = CODE_TMO;
    else if (int_en[0] && data_pend) code = CODE_DATA;
    else if (int_en[1] && txe_pend)  code = CODE_TXE;
    else if (int_en[3] && modem_pend) code = CODE_MODEM;
    else                             code = CODE_NONE;
  end

  assign iid = {fifo_mode ? 2'b11 : 2'b00, 2'b00, code};
  assign irq = (code != CODE_NONE);

endmodule

// File: rtl/uart_rx_fifo_ctl.sv
module uart_rx_fifo_ctl
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned FBW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_data,
  input  logic           lb_valid,
  input  logic [DW-1:0]  lb_data,
  input  logic           rd_strobe,
  input  logic           lsr_rd,
  input  logic           fcr_wr,
  input  logic           fcr_enable,
  input  logic           fcr_rx_clear,
  input  logic [1:0]     fcr_trig_sel,
  input  logic           mcr_wr,
  input  logic           mcr_loop,
  input  logic [3:0]     int_en,
  input  logic           tx_empty_pend,
  input  logic           modem_pend,
  input  logic           bit_tick,
  input  logic [FBW-1:0] frame_bits,
  output logic [DW-1:0]  rd_data,
  output logic           data_ready,
  output logic           overrun,
  output logic [7:0]     iid,
  output logic           irq
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned TW = FBW + 2;

  logic          fifo_en_q, loop_q, dr_q, ovr_q, rxp_q, tmo_q;
  logic [CW-1:0] trig_q;

  // named internal events
  logic          mode_flip, clear_req, loop_flip, flush;
  logic          src_push;
  logic [DW-1:0] src_byte;
  logic [CW-1:0] lvl_cur, lvl_nxt;
  logic          push_drop, tmo_fire, tmr_restart, tmr_stop;
  logic [TW-1:0] tmo_limit;

  assign mode_flip = fcr_wr && (fcr_enable != fifo_en_q);
  assign clear_req = fcr_wr && (fcr_rx_clear || !fcr_enable);
  assign loop_flip = mcr_wr && (mcr_loop != loop_q);
  assign flush     = mode_flip || clear_req || loop_flip;

  assign src_push = loop_q ? lb_valid : rx_valid;
  assign src_byte = loop_q ? lb_data  : rx_data;

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .single_mode(!fifo_en_q),
    .flush      (flush),
    .push       (src_push),
    .push_data  (src_byte),
    .pop        (rd_strobe),
    .head       (rd_data),
    .level      (lvl_cur),
    .level_next (lvl_nxt),
    .push_drop  (push_drop)
  );

  assign tmo_limit   = TW'(tmo_ticks(32'(frame_bits)));
  assign tmr_stop    = flush || !fifo_en_q || (rd_strobe && lvl_nxt == '0);
  assign tmr_restart = fifo_en_q && !flush && (src_push || (rd_strobe && lvl_nxt != '0));

  rxq_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(tmr_restart),
    .stop   (tmr_stop),
    .tick   (bit_tick),
    .limit  (tmo_limit),
    .expire (tmo_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      loop_q    <= 1'b0;
      trig_q    <= CW'(1);
      dr_q      <= 1'b0;
      rxp_q     <= 1'b0;
      tmo_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (fcr_wr) begin
        fifo_en_q <= fcr_enable;
        trig_q    <= CW'(trig_level(fcr_trig_sel));
      end
      if (mcr_wr) loop_q <= mcr_loop;

      if (flush) begin
        dr_q  <= 1'b0;
        rxp_q <= 1'b0;
        tmo_q <= 1'b0;
      end else if (fifo_en_q) begin
        if (rd_strobe) begin
          tmo_q <= 1'b0;
          if (lvl_nxt == '0) begin
            dr_q  <= 1'b0;
            rxp_q <= 1'b0;
          end
        end
        if (src_push && !push_drop && lvl_nxt >= trig_q) begin
          dr_q  <= 1'b1;
          rxp_q <= 1'b1;
        end
        if (tmo_fire) begin
          tmo_q <= 1'b1;
          dr_q  <= 1'b1;
        end
      end else begin
        if (rd_strobe) begin
          dr_q  <= 1'b0;
          rxp_q <= 1'b0;
        end
        if (src_push) begin
          dr_q  <= 1'b1;
          rxp_q <= 1'b1;
        end
      end

      if (lsr_rd) ovr_q <= 1'b0;
      if (!flush && (push_drop || (!fifo_en_q && src_push && dr_q && !rd_strobe)))
        ovr_q <= 1'b1;
    end
  end

  rxq_irq_pick u_pick (
    .int_en    (int_en),
    .line_pend (ovr_q),
    .tmo_pend  (tmo_q),
    .data_pend (rxp_q),
    .txe_pend  (tx_empty_pend),
    .modem_pend(modem_pend),
    .fifo_mode (fifo_en_q),
    .iid       (iid),
    .irq       (irq)
  );

  assign data_ready = dr_q;
  assign overrun    = ovr_q;

  // R4
  ovr_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_q && !flush && src_push && !rd_strobe && lvl_cur == CW'(DEPTH)) |=> overrun);

  // R5
  single_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en_q && !flush && src_push && data_ready && !rd_strobe) |=> overrun);

  // R6
  tmo_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (lvl_cur != '0));

  // R7
  read_clears_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !flush) |=> !tmo_q);

  // R9
  mode_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en_q |-> (iid[7:6] == 2'b11));

  // R10
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> (!data_ready && lvl_cur == '0));

  // R11
  loop_ignores_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && !mcr_wr && !fcr_wr && rx_valid && !lb_valid && !rd_strobe) |=> (lvl_cur == $past(lvl_cur)));

endmodule

// File: tb/uart_rx_fifo_ctl_tb.sv
module uart_rx_fifo_ctl_tb;

  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       rx_valid, lb_valid, rd_strobe, lsr_rd;
  logic [7:0] rx_data, lb_data;
  logic       fcr_wr, fcr_enable, fcr_rx_clear, mcr_wr, mcr_loop;
  logic [1:0] fcr_trig_sel;
  logic [3:0] int_en, frame_bits;
  logic       tx_empty_pend, modem_pend, bit_tick;
  logic [7:0] rd_data, iid;
  logic       data_ready, overrun, irq;

  uart_rx_fifo_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .lb_valid(lb_valid), .lb_data(lb_data), .rd_strobe(rd_strobe), .lsr_rd(lsr_rd),
    .fcr_wr(fcr_wr), .fcr_enable(fcr_enable), .fcr_rx_clear(fcr_rx_clear),
    .fcr_trig_sel(fcr_trig_sel), .mcr_wr(mcr_wr), .mcr_loop(mcr_loop),
    .int_en(int_en), .tx_empty_pend(tx_empty_pend), .modem_pend(modem_pend),
    .bit_tick(bit_tick), .frame_bits(frame_bits), .rd_data(rd_data),
    .data_ready(data_ready), .overrun(overrun), .iid(iid), .irq(irq)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  byte unsigned mq[$];
  bit m_fen, m_loop, m_dr, m_ovr, m_rxp, m_to, m_arm;
  int m_trig, m_cnt;

  function automatic int thr_of(input logic [1:0] s);
    int t[4] = '{1, 4, 8, 14};
    return t[s];
  endfunction

  function automatic logic [7:0] model_iid();
    logic [3:0] c;
    c = 4'h1;
    if (modem_pend && int_en[3]) c = 4'h0;
    if (tx_empty_pend && int_en[1]) c = 4'h2;
    if (m_rxp && int_en[0]) c = 4'h4;
    if (m_to && int_en[0]) c = 4'hC;
    if (m_ovr && int_en[2]) c = 4'h6;
    return {m_fen ? 2'b11 : 2'b00, 2'b00, c};
  endfunction

  always @(posedge clk) begin : model
    bit fl, touched, nfen, nloop, pv;
    int ntrig;
    byte unsigned b;
    if (!rst_n) begin
      mq.delete();
      m_fen = 0; m_loop = 0; m_dr = 0; m_ovr = 0; m_rxp = 0; m_to = 0;
      m_arm = 0; m_cnt = 0; m_trig = 1;
    end else begin
      fl = 0; touched = 0; nfen = m_fen; nloop = m_loop; ntrig = m_trig;
      if (fcr_wr) begin
        if (fcr_enable != m_fen || !fcr_enable || fcr_rx_clear) fl = 1;
        nfen = fcr_enable;
        ntrig = thr_of(fcr_trig_sel);
      end
      if (mcr_wr) begin
        if (mcr_loop != m_loop) fl = 1;
        nloop = mcr_loop;
      end
      if (lsr_rd) m_ovr = 0;
      pv = m_loop ? lb_valid : rx_valid;
      b  = m_loop ? lb_data : rx_data;
      if (fl) begin
        mq.delete(); m_dr = 0; m_rxp = 0; m_to = 0; m_arm = 0; touched = 1;
      end else if (m_fen) begin
        if (rd_strobe) begin
          if (mq.size() > 0) void'(mq.pop_front());
          m_to = 0; touched = 1;
          if (mq.size() == 0) begin m_dr = 0; m_rxp = 0; m_arm = 0; end
          else begin m_arm = 1; m_cnt = 0; end
        end
        if (pv) begin
          if (mq.size() == DEPTH) m_ovr = 1;
          else begin
            mq.push_back(b);
            if (mq.size() >= m_trig) begin m_dr = 1; m_rxp = 1; end
          end
          m_arm = 1; m_cnt = 0; touched = 1;
        end
        if (!touched && m_arm && bit_tick) begin
          if (m_cnt + 1 == 4 * int'(frame_bits)) begin m_to = 1; m_dr = 1; m_arm = 0; end
          else m_cnt++;
        end
      end else begin
        m_arm = 0;
        if (rd_strobe) begin m_dr = 0; m_rxp = 0; mq.delete(); end
        if (pv) begin
          if (m_dr) m_ovr = 1;
          mq.delete(); mq.push_back(b); m_dr = 1; m_rxp = 1;
        end
      end
      m_fen = nfen; m_loop = nloop; m_trig = ntrig;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 1 ns after the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R3 data_ready vs model", {7'd0, data_ready}, {7'd0, m_dr});
      chk("R4 overrun vs model", {7'd0, overrun}, {7'd0, m_ovr});
      chk("R8 iid vs model", iid, model_iid());
      chk("R9 irq vs model", {7'd0, irq}, {7'd0, model_iid()[3:0] != 4'h1});
      if (mq.size() > 0) chk("R2 rd_data vs model", rd_data, mq[0]);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic push_line(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic push_loop(input logic [7:0] b);
    @(negedge clk); lb_valid = 1; lb_data = b;
    @(negedge clk); lb_valid = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); d = rd_data; rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
  endtask

  task automatic lsr_read();
    @(negedge clk); lsr_rd = 1;
    @(negedge clk); lsr_rd = 0;
  endtask

  task automatic fcr(input logic en, input logic clr, input logic [1:0] sel);
    @(negedge clk); fcr_wr = 1; fcr_enable = en; fcr_rx_clear = clr; fcr_trig_sel = sel;
    @(negedge clk); fcr_wr = 0; fcr_rx_clear = 0;
  endtask

  task automatic mcr(input logic lp);
    @(negedge clk); mcr_wr = 1; mcr_loop = lp;
    @(negedge clk); mcr_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 0; rx_valid = 0; lb_valid = 0; rd_strobe = 0; lsr_rd = 0;
    rx_data = 0; lb_data = 0; fcr_wr = 0; fcr_enable = 0; fcr_rx_clear = 0;
    fcr_trig_sel = 0; mcr_wr = 0; mcr_loop = 0; int_en = 4'h0;
    tx_empty_pend = 0; modem_pend = 0; bit_tick = 0; frame_bits = 4'd10;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 data_ready", {7'd0, data_ready}, 8'd0);
    chk("R1 overrun", {7'd0, overrun}, 8'd0);
    chk("R1 iid", iid, 8'h01);
    chk("R1 irq", {7'd0, irq}, 8'd0);

    // R5 single register mode
    int_en = 4'h5;
    push_line(8'hA5);
    chk("R5 data_ready set", {7'd0, data_ready}, 8'd1);
    chk("R5 rd_data", rd_data, 8'hA5);
    chk("R8 iid receive", iid, 8'h04);
    push_line(8'h3C);
    chk("R5 overrun on second char", {7'd0, overrun}, 8'd1);
    chk("R5 overwrite", rd_data, 8'h3C);
    chk("R8 line status wins", iid, 8'h06);
    rd(d);
    chk("R5 read clears data_ready", {7'd0, data_ready}, 8'd0);
    lsr_read();
    chk("R12 lsr read clears overrun", {7'd0, overrun}, 8'd0);
    chk("R9 none pending", iid, 8'h01);

    // R3 threshold 4
    fcr(1, 0, 2'b01);
    chk("R9 mode bits", iid, 8'hC1);
    for (int i = 0; i < 3; i++) push_line(8'h10 + 8'(i));
    chk("R3 below threshold", {7'd0, data_ready}, 8'd0);
    push_line(8'h13);
    chk("R3 at threshold", {7'd0, data_ready}, 8'd1);
    chk("R3 receive interrupt", iid, 8'hC4);
    for (int i = 0; i < 4; i++) begin
      rd(d);
      chk("R2 order", d, 8'h10 + 8'(i));
    end
    chk("R7 empty clears data_ready", {7'd0, data_ready}, 8'd0);

    // R4 full queue, threshold 14
    fcr(1, 0, 2'b11);
    for (int i = 0; i < 13; i++) push_line(8'h40 + 8'(i));
    chk("R3 thirteen below 14", {7'd0, data_ready}, 8'd0);
    for (int i = 13; i < 16; i++) push_line(8'h40 + 8'(i));
    chk("R4 no overrun at 16", {7'd0, overrun}, 8'd0);
    push_line(8'hEE);
    chk("R4 overrun on 17th", {7'd0, overrun}, 8'd1);
    chk("R8 line over data", iid, 8'hC6);
    lsr_read();
    chk("R8 data after line cleared", iid, 8'hC4);
    for (int i = 0; i < 16; i++) begin
      rd(d);
      chk("R4 contents kept", d, 8'h40 + 8'(i));
    end
    chk("R4 dropped char absent", {7'd0, data_ready}, 8'd0);

    // R6 timeout with frame_bits = 10 -> 40 ticks
    int_en = 4'h1;
    push_line(8'h71);
    push_line(8'h72);
    bit_tick = 1;
    repeat (39) @(negedge clk);
    chk("R6 no timeout at 39 ticks", iid, 8'hC1);
    @(negedge clk);
    chk("R6 timeout at 40 ticks", iid, 8'hCC);
    chk("R6 timeout sets data_ready", {7'd0, data_ready}, 8'd1);
    bit_tick = 0;
    rd(d);
    chk("R2 first out", d, 8'h71);
    chk("R7 read clears timeout", iid, 8'hC1);
    chk("R7 data_ready kept with data left", {7'd0, data_ready}, 8'd1);
    bit_tick = 1;
    repeat (40) @(negedge clk);
    chk("R6 timeout after read restart", iid, 8'hCC);
    bit_tick = 0;
    rd(d);
    chk("R7 last read clears data_ready", {7'd0, data_ready}, 8'd0);

    // R8 lower sources
    tx_empty_pend = 1; int_en = 4'h2;
    @(negedge clk);
    chk("R8 transmit empty", iid, 8'hC2);
    modem_pend = 1; int_en = 4'h8;
    @(negedge clk);
    chk("R8 modem status", iid, 8'hC0);
    chk("R9 irq with modem", {7'd0, irq}, 8'd1);
    int_en = 4'h0;
    @(negedge clk);
    chk("R9 irq low when disabled", {7'd0, irq}, 8'd0);
    tx_empty_pend = 0; modem_pend = 0; int_en = 4'h1;

    // R10 disabling queue mode flushes
    fcr(1, 0, 2'b00);
    push_line(8'h55);
    push_line(8'h56);
    chk("R3 threshold 1", {7'd0, data_ready}, 8'd1);
    fcr(0, 0, 2'b00);
    chk("R10 data_ready cleared", {7'd0, data_ready}, 8'd0);
    chk("R10 iid after flush", iid, 8'h01);

    // R12 receive clear
    fcr(1, 0, 2'b00);
    push_line(8'h61);
    push_line(8'h62);
    fcr(1, 1, 2'b00);
    chk("R12 clear empties", {7'd0, data_ready}, 8'd0);
    push_line(8'h63);
    rd(d);
    chk("R12 fresh data after clear", d, 8'h63);

    // R11 loopback
    mcr(1);
    push_line(8'h11);
    chk("R11 line ignored", {7'd0, data_ready}, 8'd0);
    push_loop(8'h22);
    chk("R11 loop char stored", {7'd0, data_ready}, 8'd1);
    chk("R11 loop data", rd_data, 8'h22);
    mcr(0);
    chk("R11 toggle flushes", {7'd0, data_ready}, 8'd0);
    push_line(8'h33);
    chk("R11 line back", rd_data, 8'h33);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule